// File: doc/BRIEF.md
# Segmented Compressor Load Balancer

This controller sits in a segmented state-backup path. The saved state vector is cut into NUM_SEG segments, and each segment has its own compression engine. When a backup starts, every engine is launched at the same moment on the private part of its own segment. Some segments are marked shareable in SHARE_MASK. The last piece of such a segment, its shared part, reaches the engines through multiplexers. A fixed segment has no shared part and is never rerouted.

While the backup runs, the controller watches the done flags and the remaining-bit counts that the engines report. An engine that finishes the private part of a shareable segment normally takes its own shared part next. An engine that goes idle with nothing of its own left borrows the shared part of the slowest shareable segment that is still busy. That shared part then goes to the idle engine. The owner no longer has to handle it after its private part. When every engine is idle and nothing is left to hand out, the controller pulses a completion flag.

The control is a three-state machine:
- ST_IDLE waits for `go`. The transition "launch" starts all engines and moves to ST_RUN.
- ST_RUN balances the work. The transition "drain complete" is taken when no engine is active after the current cycle's updates. It moves to ST_FIN.
- ST_FIN raises `all_done` for one cycle. The transition "rearm" then returns to ST_IDLE.

Top module: `seg_load_balancer`

## Requirements
- R1: After reset, `eng_start`, `shr_route` and `all_done` are all zero. A `go` pulse in ST_IDLE makes `eng_start` all ones in the next cycle, with `shr_route` zero, which means every engine works on its private part. A `go` seen in ST_RUN or ST_FIN causes no start.
- R2: Take an engine e of a shareable segment whose shared part is still unclaimed. When e reports done on its private part, e is restarted in the next cycle on its own shared part. That cycle shows `eng_start[e]`=1 and `shr_route[e*NUM_SEG+e]`=1.
- R3: A fixed segment's route bits `shr_route[s*NUM_SEG +: NUM_SEG]` stay zero. An engine that goes idle when no candidate exists gets no start.
- R4: An idle engine e with nothing of its own to do borrows a shared part in the next cycle, with `eng_start[e]`=1 and `shr_route[s*NUM_SEG+e]`=1. The part it takes belongs to the candidate segment s with the largest `eng_remain[s*CNT_W +: CNT_W]`. A candidate is a segment that is shareable, unclaimed, and whose owner is still busy on its private part. Ties go to the lowest s.
- R5: Each shared part is started at most once per backup. An owner that finishes its private part after its shared part was claimed receives no start.
- R6: Each route row is one-hot or zero. A route bit stays set from its start cycle until the cycle after that engine reports done, and is zero from then on.
- R7: Suppose an owner finishes in the same cycle that another engine goes idle. The owner keeps its own shared part, and the other engine takes the best remaining candidate, or nothing if none is left. Several idle engines are served in ascending engine index.
- R8: `all_done` is high for exactly one cycle. It comes in the cycle after the last done flag, once no reassignment is pending. A new `go` is accepted afterwards.
- R9: A done flag from an engine that holds no job is ignored: it causes no start and does not change routing or completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a backup (used in ST_IDLE only) |
| eng_done | input | NUM_SEG | Per-engine one-cycle job-finished flag |
| eng_remain | input | NUM_SEG*CNT_W | Per-engine bits left in the current private job |
| eng_start | output | NUM_SEG | Per-engine start strobe |
| shr_route | output | NUM_SEG*NUM_SEG | Mux selects; bit s*NUM_SEG+e routes segment s's shared part to engine e |
| all_done | output | 1 | One-cycle backup-complete pulse |

## Verification
Within one cycle, an owner claiming its own shared part and an idle engine borrowing another segment's shared part can both fall due. These two claims compete for the same pool of candidates. The bench provokes this by raising two or three done flags together. In that setup the finishing owner holds the largest remaining count, so a wrong arbitration order would hand that owner's part to the idle engine. The scoreboard then judges which engine started and from which route the start came, and it also checks that an engine left without a candidate receives no start at all.

// File: rtl/slb_pkg.sv
package slb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } slb_state_e;

endpackage

// File: rtl/slb_fsm.sv
module slb_fsm
    import slb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic finish,
    output logic launch,
    output logic run,
    output logic all_done
);

    slb_state_e state_q;
    slb_state_e state_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state and outputs
    always_comb begin
        state_n  = state_q;
        launch   = 1'b0;
        run      = 1'b0;
        all_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                launch = go;
                if (go) state_n = ST_RUN;
            end
            ST_RUN: begin
                run = 1'b1;
                if (finish) state_n = ST_FIN;
            end
            ST_FIN: begin
                all_done = 1'b1;
                state_n  = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assert_fin_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |=> !all_done);

    assert_no_launch_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !launch);

endmodule

// File: rtl/slb_pick.sv
module slb_pick #(
    parameter int NUM_SEG = 3,
    parameter int CNT_W   = 8
) (
    input  logic [NUM_SEG-1:0]         cand,
    input  logic [NUM_SEG-1:0]         idle_req,
    input  logic [NUM_SEG*CNT_W-1:0]   remain,
    output logic [NUM_SEG*NUM_SEG-1:0] gnt
);

    // Engines are served in ascending index; each takes the largest
    // remaining candidate not yet taken in this cycle (lowest index on tie).
    always_comb begin
        logic [NUM_SEG-1:0] taken;
        logic               found;
        int                 best;
        logic [CNT_W-1:0]   bval;
        taken = '0;
        gnt   = '0;
        for (int e = 0; e < NUM_SEG; e++) begin
            found = 1'b0;
            best  = 0;
            bval  = '0;
            if (idle_req[e]) begin
                for (int s = 0; s < NUM_SEG; s++) begin
                    if (cand[s] && !taken[s] &&
                        (!found || remain[s*CNT_W +: CNT_W] > bval)) begin
                        found = 1'b1;
                        best  = s;
                        bval  = remain[s*CNT_W +: CNT_W];
                    end
                end
                if (found) begin
                    gnt[e*NUM_SEG + best] = 1'b1;
                    taken[best]           = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/seg_load_balancer.sv
module seg_load_balancer #(
    parameter int                 NUM_SEG    = 3,
    parameter int                 CNT_W      = 8,
    parameter logic [NUM_SEG-1:0] SHARE_MASK = 3'b011
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go,
    input  logic [NUM_SEG-1:0]         eng_done,
    input  logic [NUM_SEG*CNT_W-1:0]   eng_remain,
    output logic [NUM_SEG-1:0]         eng_start,
    output logic [NUM_SEG*NUM_SEG-1:0] shr_route,
    output logic                       all_done
);

    localparam logic [NUM_SEG-1:0] ALL_ONE = '1;

    logic launch, run, finish;

    logic [NUM_SEG-1:0]              priv_q, priv_n;
    logic [NUM_SEG-1:0]              assigned_q, assigned_n;
    logic [NUM_SEG-1:0]              start_q, start_n;
    logic [NUM_SEG-1:0][NUM_SEG-1:0] route_q, route_n;   // [segment][engine]
    logic [NUM_SEG-1:0][NUM_SEG-1:0] col_q;              // [engine][segment]
    logic [NUM_SEG-1:0]              shr_act;
    logic [NUM_SEG-1:0]              done_v, own_claim, cand, idle_req;
    logic [NUM_SEG-1:0]              gnt_eng, gnt_seg;
    logic [NUM_SEG*NUM_SEG-1:0]      gnt;

    slb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .finish   (finish),
        .launch   (launch),
        .run      (run),
        .all_done (all_done)
    );

    always_comb begin
        for (int e = 0; e < NUM_SEG; e++) begin
            shr_act[e] = 1'b0;
            for (int s = 0; s < NUM_SEG; s++) begin
                col_q[e][s] = route_q[s][e];
                shr_act[e]  = shr_act[e] | route_q[s][e];
            end
        end
    end

    assign done_v    = eng_done & (priv_q | shr_act);
    assign own_claim = {NUM_SEG{run}} & SHARE_MASK & done_v & priv_q & ~assigned_q;
    assign cand      = {NUM_SEG{run}} & SHARE_MASK & priv_q & ~done_v & ~assigned_q;
    assign idle_req  = {NUM_SEG{run}} & ~own_claim & (~(priv_q | shr_act) | done_v);

    slb_pick #(
        .NUM_SEG (NUM_SEG),
        .CNT_W   (CNT_W)
    ) u_pick (
        .cand     (cand),
        .idle_req (idle_req),
        .remain   (eng_remain),
        .gnt      (gnt)
    );

    always_comb begin
        for (int e = 0; e < NUM_SEG; e++) begin
            gnt_eng[e] = |gnt[e*NUM_SEG +: NUM_SEG];
        end
        for (int s = 0; s < NUM_SEG; s++) begin
            gnt_seg[s] = 1'b0;
            for (int e = 0; e < NUM_SEG; e++) begin
                gnt_seg[s] = gnt_seg[s] | gnt[e*NUM_SEG + s];
            end
        end
        for (int s = 0; s < NUM_SEG; s++) begin
            for (int e = 0; e < NUM_SEG; e++) begin
                route_n[s][e] = !launch && SHARE_MASK[s] &&
                                ((route_q[s][e] && !done_v[e]) ||
                                 (own_claim[s] && (s == e)) ||
                                 gnt[e*NUM_SEG + s]);
            end
        end
        priv_n     = launch ? ALL_ONE : (priv_q & ~done_v);
        assigned_n = launch ? '0 : (assigned_q | own_claim | gnt_seg);
        start_n    = launch ? ALL_ONE : (own_claim | gnt_eng);
        finish     = run && (priv_n == '0) && (route_n == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q     <= '0;
            assigned_q <= '0;
            start_q    <= '0;
            route_q    <= '0;
        end else begin
            priv_q     <= priv_n;
            assigned_q <= assigned_n;
            start_q    <= start_n;
            route_q    <= route_n;
        end
    end

    assign eng_start = start_q;
    assign shr_route = route_q;

    assert_launch_private_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(launch) |-> (eng_start == ALL_ONE && route_q == '0));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> (priv_q == '0 && shr_act == '0));

    assert_start_has_job_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start != '0 |-> ((eng_start & ~(priv_q | shr_act)) == '0));

    genvar gs, ge;
    generate
        for (gs = 0; gs < NUM_SEG; gs++) begin : g_seg_chk
            assert_route_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(route_q[gs]));
            assert_share_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(|route_q[gs]) |-> !$past(assigned_q[gs]));
            for (ge = 0; ge < NUM_SEG; ge++) begin : g_eng_chk
                assert_borrow_from_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(route_q[gs][ge]) |-> $past(priv_q[gs]));
            end
        end
        for (ge = 0; ge < NUM_SEG; ge++) begin : g_job_chk
            assert_one_job_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({priv_q[ge], col_q[ge]}));
        end
    endgenerate

endmodule

// File: tb/seg_load_balancer_test.sv
module seg_load_balancer_test;

    localparam int M    = 3;
    localparam int W    = 8;
    localparam int PRIV = 3;
    localparam int EVD  = 100;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           go;
    logic [M-1:0]   eng_done;
    logic [M*W-1:0] eng_remain;
    logic [M-1:0]   eng_start;
    logic [M*M-1:0] shr_route;
    logic           all_done;

    always #10 clk = ~clk;

    seg_load_balancer #(.NUM_SEG(M), .CNT_W(W), .SHARE_MASK(3'b011)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .eng_done   (eng_done),
        .eng_remain (eng_remain),
        .eng_start  (eng_start),
        .shr_route  (shr_route),
        .all_done   (all_done)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string tag_q[$];

    function automatic void check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    task automatic expect_ev(int e, int src, string tag);
        exp_q.push_back(e * 8 + src);
        tag_q.push_back(tag);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_done(logic [M-1:0] m);
        eng_done = m;
        tick();
        eng_done = '0;
    endtask

    task automatic launch(int r0, int r1, int r2);
        eng_remain = {r2[W-1:0], r1[W-1:0], r0[W-1:0]};
        for (int e = 0; e < M; e++) expect_ev(e, PRIV, "R1 launch private");
        go = 1'b1;
        tick();
        go = 1'b0;
        check(shr_route == '0, "R1 launch route", int'(shr_route), 0);
        go = 1'b1;
        tick();
        go = 1'b0;
        check(eng_start == '0, "R1 go ignored in run", int'(eng_start), 0);
    endtask

    task automatic finish_with(logic [M-1:0] m, string tag);
        expect_ev(EVD, 0, tag);
        pulse_done(m);
        check(all_done == 1'b1, tag, int'(all_done), 1);
        tick();
        check(all_done == 1'b0, "R8 single pulse", int'(all_done), 0);
        check(exp_q.size() == 0, "R8 missing event", exp_q.size(), 0);
        tick();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int e = 0; e < M; e++) begin
                if (eng_start[e]) begin
                    int src;
                    int got;
                    src = PRIV;
                    for (int s = 0; s < M; s++) if (shr_route[s*M + e]) src = s;
                    got = e * 8 + src;
                    if (exp_q.size() == 0) check(1'b0, "R5 unexpected start", got, -1);
                    else begin
                        string t;
                        int    x;
                        t = tag_q.pop_front();
                        x = exp_q.pop_front();
                        check(got == x, t, got, x);
                    end
                end
            end
            if (all_done) begin
                if (exp_q.size() == 0) check(1'b0, "R8 unexpected done", EVD * 8, -1);
                else begin
                    string t;
                    int    x;
                    t = tag_q.pop_front();
                    x = exp_q.pop_front();
                    check(x == EVD * 8, t, EVD * 8, x);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        go         = 1'b0;
        eng_done   = '0;
        eng_remain = '0;
        repeat (3) tick();
        check(eng_start == '0 && shr_route == '0 && all_done == 1'b0,
              "R1 reset state", int'({all_done, shr_route, eng_start}), 0);
        rst_n = 1'b1;
        tick();
        pulse_done(3'b111);
        check(eng_start == '0, "R9 done while idle", int'(eng_start), 0);
        tick();

        // A: slowest segment borrowed, own shared part, stray done
        launch(10, 40, 0);
        expect_ev(2, 1, "R4 slowest borrowed");
        pulse_done(3'b100);
        check(shr_route == 9'b000_100_000, "R6 route set", int'(shr_route), 9'b000_100_000);
        expect_ev(0, 0, "R2 own shared part");
        pulse_done(3'b001);
        pulse_done(3'b010);
        check(eng_start == '0, "R5 claimed part not restarted", int'(eng_start), 0);
        pulse_done(3'b010);
        check(eng_start == '0 && all_done == 1'b0, "R9 stray done", int'(eng_start), 0);
        check(shr_route == 9'b000_100_001, "R9 route untouched", int'(shr_route), 9'b000_100_001);
        pulse_done(3'b100);
        check(shr_route == 9'b000_000_001, "R6 route released", int'(shr_route), 9'b000_000_001);
        finish_with(3'b001, "R8 done after last");

        // B: tie goes to lowest index
        launch(20, 20, 0);
        expect_ev(2, 0, "R4 tie lowest index");
        pulse_done(3'b100);
        expect_ev(1, 1, "R2 own shared seg1");
        pulse_done(3'b010);
        pulse_done(3'b001);
        check(eng_start == '0, "R5 owner after borrow", int'(eng_start), 0);
        pulse_done(3'b100);
        check(eng_start == '0, "R3 no candidate left", int'(eng_start), 0);
        finish_with(3'b010, "R8 done B");

        // C: owner and idle engine in the same cycle
        launch(50, 30, 0);
        expect_ev(0, 0, "R7 owner keeps own part");
        expect_ev(2, 1, "R7 idle takes next");
        pulse_done(3'b101);
        check(shr_route == 9'b000_100_001, "R7 routes", int'(shr_route), 9'b000_100_001);
        pulse_done(3'b010);
        finish_with(3'b101, "R8 done C");

        // E: all engines finish together
        launch(5, 5, 0);
        expect_ev(0, 0, "R7 all finish seg0");
        expect_ev(1, 1, "R7 all finish seg1");
        pulse_done(3'b111);
        check(eng_start == 3'b011, "R7 no spare part", int'(eng_start), 3);
        check(shr_route[8:6] == 3'b000, "R3 fixed row zero", int'(shr_route[8:6]), 0);
        finish_with(3'b011, "R8 done E");

        // F: an engine that finished its own shared part borrows later
        launch(0, 60, 0);
        expect_ev(0, 0, "R2 own shared first");
        pulse_done(3'b001);
        expect_ev(0, 1, "R4 reuse idle engine");
        pulse_done(3'b001);
        pulse_done(3'b010);
        pulse_done(3'b100);
        check(eng_start == '0, "R3 fixed engine idle", int'(eng_start), 0);
        finish_with(3'b001, "R8 done F");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule